// File: doc/BRIEF.md
# Slack Priority Tag Estimator

This block sits at the injection point of a core's network interface and labels every outgoing miss request with a 5-bit slack tag. A request whose reply can arrive late without hurting the core gets a larger tag. A request that the core is waiting on gets a smaller tag. Routers downstream serve lower tags first. The tag combines three things: how many of the requests already in flight are expected to go all the way to memory, whether this request is itself expected to hit in L2, and how many more mesh hops the farthest in-flight request travels than this one.

The estimator keeps a fixed-depth table of outstanding requests. Each entry records the L2 prediction made for that request at issue and its hop distance from the core. A small predictor remembers the L2 outcomes of the most recent completions and declares an L2 miss when enough of them were misses. The tag, the table slot and the ready signal are combinational in the cycle the request is presented. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A completion names the slot to free and reports whether that request actually missed in L2.

The table occupancy is tracked by a three-state machine:
- `Q_EMPTY` moves to `Q_ACTIVE` on an accepted request, or straight to `Q_FULL` when the depth is one.
- `Q_ACTIVE` moves to `Q_EMPTY` when the next count is zero, moves to `Q_FULL` when the next count reaches the depth, and otherwise stays.
- `Q_FULL` moves to `Q_ACTIVE` on a completion, or to `Q_EMPTY` when the depth is one.

Top module: `slk_tag_est`

## Requirements
- R1: `req_tag[4:3]` equals the number of held entries whose stored prediction was "L2 miss", saturated at 3.
- R2: `req_tag[2]` is 1 when the predictor currently expects an L2 hit, and 0 when it expects an L2 miss.
- R3: `req_tag[1:0]` equals the largest hop count among held entries minus the request's own hop count, clamped to 0..3. A negative difference gives 0, and an empty table gives 0.
- R4: A request's hop count is |dst_x − SELF_X| + |dst_y − SELF_Y|.
- R5: The predictor expects an L2 miss when at least MISS_T of the last HIST_M completion outcomes were misses. Its history is all hits after reset and changes only on a completion.
- R6: The entries counted for a request are those held at the start of its cycle, including an entry being completed in that same cycle. Each accepted request stores the prediction in force at its issue together with its own hop count.
- R7: `req_slot` is the lowest-numbered free entry, and a completion frees the slot it names.
- R8: `req_ready` is low exactly when all DEPTH entries are held. A request presented while `req_ready` is low is not stored.
- R9: After reset the table is empty, `req_ready` is high, `req_slot` is 0, and a request at the core's own position gets tag 4 (binary 00100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New miss request presented |
| req_dst_x | input | CW | Destination column |
| req_dst_y | input | CW | Destination row |
| req_ready | output | 1 | Table has a free entry |
| req_tag | output | 5 | Slack tag for the presented request |
| req_slot | output | clog2(DEPTH) | Slot the request will occupy |
| cmp_valid | input | 1 | A request has completed |
| cmp_slot | input | clog2(DEPTH) | Slot of the completed request |
| cmp_l2_miss | input | 1 | Completed request missed in L2 |

## Verification
The assertions assume that a completion only ever names a slot that is currently held, and that no completion arrives while the table is empty. The stimulus meets both conditions: it issues completions only for slots it has itself seen accepted and not yet freed. The bench uses these slots and the requests' coordinates to build its expected tags by hand from the field definitions. A full table is reached by filling all entries at the core's own position, and a request presented while full is held for a cycle before a completion reopens a slot.

// File: rtl/slk_pkg.sv
package slk_pkg;

    localparam int TAG_W    = 5;
    localparam int PRED_W   = 2;
    localparam int HOPEST_W = 2;

    typedef enum logic [1:0] {
        Q_EMPTY  = 2'd0,
        Q_ACTIVE = 2'd1,
        Q_FULL   = 2'd2
    } slk_qstate_e;

    typedef struct packed {
        logic [PRED_W-1:0]   pred_cnt;
        logic                mine_hit;
        logic [HOPEST_W-1:0] hop_est;
    } slk_tag_t;

endpackage

// File: rtl/slk_miss_pred.sv
module slk_miss_pred #(
    parameter int HIST_M = 4,
    parameter int MISS_T = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_valid,
    input  logic cmp_l2_miss,
    output logic pred_miss
);

    logic [HIST_M-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (cmp_valid) begin
            hist_q <= {hist_q[HIST_M-2:0], cmp_l2_miss};
        end
    end

    always_comb begin
        pred_miss = ($countones(hist_q) >= MISS_T);
    end

    // The prediction may only change when a completion updates the history
    AST_PRED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(pred_miss)); // R5

endmodule

// File: rtl/slk_outq.sv
module slk_outq
    import slk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int HOP_W = 4,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             alloc_pm,
    input  logic [HOP_W-1:0] alloc_hop,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_slot,
    output logic             full,
    output logic             empty,
    output logic [IDX_W-1:0] free_idx,
    output logic [1:0]       pm_cnt,
    output logic [HOP_W-1:0] max_hop
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SUM_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] ent_v;
    logic [DEPTH-1:0] ent_pm;
    logic [HOP_W-1:0] ent_hop [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             cmp_hit;
    logic [SUM_W-1:0] pm_sum;
    slk_qstate_e      state_q;
    slk_qstate_e      state_nx;

    assign cmp_hit = cmp_valid && ent_v[cmp_slot];

    // Entry storage: set on allocation, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            ent_pm <= '0;
            for (int i = 0; i < DEPTH; i++) ent_hop[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc && (free_idx == IDX_W'(i))) begin
                    ent_v[i]   <= 1'b1;
                    ent_pm[i]  <= alloc_pm;
                    ent_hop[i] <= alloc_hop;
                end else if (cmp_hit && (cmp_slot == IDX_W'(i))) begin
                    ent_v[i] <= 1'b0;
                end
            end
        end
    end

    // Lowest free slot
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_v[i]) free_idx = IDX_W'(i);
        end
    end

    // Predicted-miss count and farthest predecessor
    always_comb begin
        pm_sum  = '0;
        max_hop = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_v[i]) begin
                pm_sum = pm_sum + SUM_W'(ent_pm[i]);
                if (ent_hop[i] > max_hop) max_hop = ent_hop[i];
            end
        end
        pm_cnt = (pm_sum > SUM_W'(3)) ? 2'd3 : pm_sum[1:0];
    end

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end

    assign cnt_nx = cnt_q + CNT_W'(alloc) - CNT_W'(cmp_hit);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (alloc) state_nx = (cnt_nx == CNT_W'(DEPTH)) ? Q_FULL : Q_ACTIVE;
            end
            Q_ACTIVE: begin
                if (cnt_nx == '0)                 state_nx = Q_EMPTY;
                else if (cnt_nx == CNT_W'(DEPTH)) state_nx = Q_FULL;
            end
            Q_FULL: begin
                if (cmp_hit) state_nx = (cnt_nx == '0) ? Q_EMPTY : Q_ACTIVE;
            end
            default: state_nx = Q_EMPTY;
        endcase
    end

    // Outputs from state
    always_comb begin
        full  = (state_q == Q_FULL);
        empty = (state_q == Q_EMPTY);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R8

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !ent_v[free_idx]); // R7

    AST_CMP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> ent_v[cmp_slot]); // R6

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !cmp_valid) |=> full); // R8

endmodule

// File: rtl/slk_tag_est.sv
module slk_tag_est
    import slk_pkg::*;
#(
    parameter int CW     = 3,
    parameter int SELF_X = 3,
    parameter int SELF_Y = 3,
    parameter int DEPTH  = 8,
    parameter int HIST_M = 4,
    parameter int MISS_T = 2,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CW-1:0]    req_dst_x,
    input  logic [CW-1:0]    req_dst_y,
    output logic             req_ready,
    output logic [TAG_W-1:0] req_tag,
    output logic [IDX_W-1:0] req_slot,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_slot,
    input  logic             cmp_l2_miss
);

    localparam int            HOP_W = CW + 1;
    localparam logic [CW-1:0] SX    = CW'(SELF_X);
    localparam logic [CW-1:0] SY    = CW'(SELF_Y);

    logic             pred_miss;
    logic             q_full;
    logic             q_empty;
    logic [1:0]       pm_cnt;
    logic [HOP_W-1:0] max_hop;
    logic [CW-1:0]    dx;
    logic [CW-1:0]    dy;
    logic [HOP_W-1:0] own_hop;
    logic [HOP_W-1:0] hop_diff;
    logic             accept;
    slk_tag_t         tag_s;

    slk_miss_pred #(
        .HIST_M(HIST_M),
        .MISS_T(MISS_T)
    ) pred_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_valid  (cmp_valid),
        .cmp_l2_miss(cmp_l2_miss),
        .pred_miss  (pred_miss)
    );

    slk_outq #(
        .DEPTH(DEPTH),
        .HOP_W(HOP_W),
        .IDX_W(IDX_W)
    ) outq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (accept),
        .alloc_pm (pred_miss),
        .alloc_hop(own_hop),
        .cmp_valid(cmp_valid),
        .cmp_slot (cmp_slot),
        .full     (q_full),
        .empty    (q_empty),
        .free_idx (req_slot),
        .pm_cnt   (pm_cnt),
        .max_hop  (max_hop)
    );

    assign req_ready = !q_full;
    assign accept    = req_valid && req_ready;

    // Manhattan distance from this core
    always_comb begin
        dx      = (req_dst_x >= SX) ? (req_dst_x - SX) : (SX - req_dst_x);
        dy      = (req_dst_y >= SY) ? (req_dst_y - SY) : (SY - req_dst_y);
        own_hop = HOP_W'(dx) + HOP_W'(dy);
    end

    // Tag assembly
    always_comb begin
        hop_diff       = (max_hop > own_hop) ? (max_hop - own_hop) : '0;
        tag_s.pred_cnt = pm_cnt;
        tag_s.mine_hit = !pred_miss;
        tag_s.hop_est  = (hop_diff > HOP_W'(3)) ? 2'd3 : hop_diff[1:0];
        req_tag        = tag_s;
    end

    AST_EMPTY_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (req_tag[4:3] == 2'b00 && req_tag[1:0] == 2'b00)); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !cmp_valid) |=> !req_ready); // R8

endmodule

// File: tb/slk_tag_est_tb.sv
module slk_tag_est_tb_top;

    localparam int NVEC = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_dst_x = 3'd3;
    logic [2:0] req_dst_y = 3'd3;
    logic       req_ready;
    logic [4:0] req_tag;
    logic [2:0] req_slot;
    logic       cmp_valid = 1'b0;
    logic [2:0] cmp_slot = 3'd0;
    logic       cmp_l2_miss = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    // {is_issue, x, y, slot, miss, exp_tag}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 3'd3, 3'd3, 3'd0, 1'b0, 5'd4},
        {1'b1, 3'd7, 3'd7, 3'd1, 1'b0, 5'd4},
        {1'b1, 3'd3, 3'd4, 3'd2, 1'b0, 5'd7},
        {1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 5'd0},
        {1'b0, 3'd0, 3'd0, 3'd1, 1'b1, 5'd0},
        {1'b1, 3'd5, 3'd3, 3'd0, 1'b0, 5'd0},
        {1'b1, 3'd3, 3'd3, 3'd1, 1'b0, 5'd10},
        {1'b1, 3'd4, 3'd3, 3'd3, 1'b0, 5'd17},
        {1'b1, 3'd0, 3'd0, 3'd4, 1'b0, 5'd24},
        {1'b1, 3'd3, 3'd3, 3'd5, 1'b0, 5'd27},
        {1'b0, 3'd0, 3'd0, 3'd4, 1'b0, 5'd0},
        {1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 5'd0},
        {1'b0, 3'd0, 3'd0, 3'd1, 1'b0, 5'd0},
        {1'b1, 3'd3, 3'd2, 3'd0, 1'b0, 5'd20}
    };

    slk_tag_est dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_dst_x  (req_dst_x),
        .req_dst_y  (req_dst_y),
        .req_ready  (req_ready),
        .req_tag    (req_tag),
        .req_slot   (req_slot),
        .cmp_valid  (cmp_valid),
        .cmp_slot   (cmp_slot),
        .cmp_l2_miss(cmp_l2_miss)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic chk_tag(input int exp);
        chk("R1 pred field", int'(req_tag[4:3]), (exp >> 3) & 3);
        chk("R2 own-hit bit", int'(req_tag[2]), (exp >> 2) & 1);
        chk("R3 hop field", int'(req_tag[1:0]), exp & 3);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        cmp_valid = 1'b0;
        cmp_l2_miss = 1'b0;
        cmp_slot = 3'd0;
        req_dst_x = 3'd3;
        req_dst_y = 3'd3;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input int x, input int y);
        @(negedge clk);
        idle();
        req_valid = 1'b1;
        req_dst_x = 3'(x);
        req_dst_y = 3'(y);
        @(posedge clk);
    endtask

    initial begin
        do_reset();

        // R9: reset state
        #1;
        chk("R9 ready", int'(req_ready), 1);
        chk("R9 slot", int'(req_slot), 0);
        chk("R9 tag", int'(req_tag), 4);

        // Vector walk: R1 R2 R3 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v;
            v = VEC[i];
            @(negedge clk);
            idle();
            if (v[15]) begin
                req_valid = 1'b1;
                req_dst_x = v[14:12];
                req_dst_y = v[11:9];
            end else begin
                cmp_valid = 1'b1;
                cmp_slot = v[8:6];
                cmp_l2_miss = v[5];
            end
            #1;
            if (v[15]) begin
                chk_tag(int'(v[4:0]));
                chk("R7 slot", int'(req_slot), int'(v[8:6]));
            end else begin
                chk("R8 ready", int'(req_ready), 1);
            end
            @(posedge clk);
        end

        // R4: hop distance against one predecessor at hop 8
        do_reset();
        issue(7, 7);
        @(negedge clk);
        idle();
        req_dst_x = 3'd7; req_dst_y = 3'd6; #1;
        chk("R4 hop 7", int'(req_tag[1:0]), 1);
        req_dst_x = 3'd5; req_dst_y = 3'd6; #1;
        chk("R4 hop 5", int'(req_tag[1:0]), 3);
        req_dst_x = 3'd1; req_dst_y = 3'd0; #1;
        chk("R4 hop 5 negative deltas", int'(req_tag[1:0]), 3);
        req_dst_x = 3'd7; req_dst_y = 3'd7; #1;
        chk("R4 hop 8", int'(req_tag[1:0]), 0);

        // R6: completion in the same cycle still counts as predecessor
        @(negedge clk);
        idle();
        req_valid = 1'b1;
        cmp_valid = 1'b1;
        cmp_slot = 3'd0;
        cmp_l2_miss = 1'b1;
        #1;
        chk("R6 same-cycle tag", int'(req_tag), 7);
        chk("R6 same-cycle slot", int'(req_slot), 1);
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
        chk("R6 freed slot reused", int'(req_slot), 0);
        chk("R6 hop after completion", int'(req_tag), 4);

        // R8: fill the table, stall, reopen
        do_reset();
        for (int k = 0; k < 8; k++) issue(3, 3);
        @(negedge clk);
        idle();
        req_valid = 1'b1;
        req_dst_x = 3'd0;
        req_dst_y = 3'd0;
        #1;
        chk("R8 full not ready", int'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        idle();
        cmp_valid = 1'b1;
        cmp_slot = 3'd5;
        #1;
        chk("R8 still full before completion", int'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
        chk("R8 ready after completion", int'(req_ready), 1);
        chk("R8 reopened slot", int'(req_slot), 5);
        chk("R8 stalled request not stored", int'(req_tag[1:0]), 0);
        issue(3, 3);
        @(negedge clk);
        idle();
        #1;
        chk("R8 full again", int'(req_ready), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule